// File: doc/BRIEF.md
# Multi-Thread Timeslot Gate Scheduler

This block closes egress gates on a small switch according to a time schedule. It keeps one shared table of timeslots. Each timeslot holds a duration, the set of destination ports it applies to, a reserve-enable bit and a mask of the traffic-class gates it closes. Up to eight execution threads share this table. Each thread owns a contiguous range of it, given by a start address and an end index, and walks that range over and over. While a thread sits in a timeslot, that timeslot's closed-gate mask drives every port named in the slot's destination set.

Durations are counted in time units. A built-in prescaler turns `TICK_DIV` system clocks into one unit, which is 200 ns at the default 200 MHz clock. A local time counter counts units from the moment the scheduler starts. Thread i is released once the local time reaches the schedule base time plus that thread's start offset. The tables are loaded through a write port, and only while the scheduler is disabled. Illegal slot durations and a base time of zero raise a sticky error flag.

The scheduler controller has three states: `SC_OFF`, `SC_RUN` and `SC_FAULT`. It moves from OFF to RUN when `sched_en` rises with a non-zero base time. It moves from OFF to FAULT when `sched_en` rises with a base time of zero. It returns to OFF from RUN or FAULT when `sched_en` falls. Each thread has three states: `TH_IDLE`, `TH_WAIT` and `TH_RUN`. A thread moves from IDLE to WAIT when its go signal is set. It moves from WAIT to RUN when the local time reaches its start time. It falls back to IDLE from WAIT or RUN when go drops. Inside RUN, the thread advances to the next slot when the current slot's last unit expires.

Top module: `gcs_sched`

## Requirements
- R1: After reset, `gate_closed` is all zero, `conflict` is 0 and `cfg_err` is 0, and every table entry is zero.
- R2: Thread i enters its first slot once the local time counter (units since the scheduler entered RUN) is at least `sched_base` plus the thread's start offset. Until then, it drives no gates.
- R3: A thread starts at its start address and steps through consecutive indices up to its end index. After the end index it wraps back to the start address.
- R4: Each slot stays current for exactly its duration field, in units, and one unit is `TICK_DIV` clock cycles.
- R5: The closed mask of a slot is applied only when its reserve-enable bit is set. It drives the slot's destination ports only. Port p occupies `gate_closed[p*N_TC +: N_TC]`, and a 1 means that gate is closed.
- R6: Threads whose index is greater than `thread_last` never start.
- R7: A slot write whose duration is 0, or is 2^19 or more, is discarded and sets the sticky `cfg_err`. Slot word fields: duration in bits [19:0], closed mask in [27:20], reserve-enable in bit 28, destination ports in [33:29].
- R8: Raising `sched_en` while `sched_base` is zero sets `cfg_err` and starts no thread.
- R9: Table writes are ignored while `sched_en` is high or the scheduler is not OFF. `cfg_sel` selects the target: 0 is the slot table, 1 is a start entry (offset in [19:0], start address in [23:20]), and 2 is an end index (in [3:0]).
- R10: When several running threads target the same port, their closed masks are ORed on that port and `conflict` is 1.
- R11: Within four cycles after `sched_en` falls, all gates read open and `conflict` is 0. The local time restarts from zero on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sched_en | input | 1 | Scheduler enable |
| sched_base | input | TIME_W | Schedule base time in units, must be non-zero |
| thread_last | input | TIDX_W | Index of the highest used thread (used count minus one) |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 slot, 1 start entry, 2 end index |
| cfg_addr | input | SIDX_W | Slot or thread index to write |
| cfg_wdata | input | CFG_W | Write data |
| gate_closed | output | N_PORTS*N_TC | Per-port closed-gate masks |
| conflict | output | 1 | More than one running thread targets one port |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions assume that `thread_last` and `sched_base` stay constant while the scheduler is enabled. They also assume that, in every used thread, the end index is not below the start address and that end indices do not decrease across threads. The bench changes those inputs and tables only after `sched_en` has been low for several cycles. It programs every used thread with a well-formed, monotonic range. Writes made while running are issued only to show that they are discarded.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int DELTA_FIELD_W = 20;
    localparam int DELTA_OVF_BIT = 19;

    localparam logic [1:0] CFG_SLOT  = 2'd0;
    localparam logic [1:0] CFG_ENTRY = 2'd1;
    localparam logic [1:0] CFG_END   = 2'd2;

    typedef enum logic [1:0] {
        SC_OFF   = 2'd0,
        SC_RUN   = 2'd1,
        SC_FAULT = 2'd2
    } sched_state_e;

    typedef enum logic [1:0] {
        TH_IDLE = 2'd0,
        TH_WAIT = 2'd1,
        TH_RUN  = 2'd2
    } thread_state_e;

endpackage

// File: rtl/gcs_timebase.sv
module gcs_timebase #(
    parameter int TICK_DIV = 40,
    parameter int TIME_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              tick,
    output logic [TIME_W-1:0] now
);
    localparam int PW = $clog2(TICK_DIV + 1);

    logic [PW-1:0] pre_q;

    assign tick = run && (pre_q == PW'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            now   <= '0;
        end else if (!run) begin
            pre_q <= '0;
            now   <= '0;
        end else if (tick) begin
            pre_q <= '0;
            now   <= now + TIME_W'(1);
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end
endmodule

// File: rtl/gcs_thread.sv
module gcs_thread
    import gcs_pkg::*;
#(
    parameter int SIDX_W = 4,
    parameter int DW     = 20,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick,
    input  logic [TIME_W-1:0] now,
    input  logic [TIME_W:0]   start_time,
    input  logic [SIDX_W-1:0] start_addr,
    input  logic [SIDX_W-1:0] end_idx,
    input  logic [DW-1:0]     ld_delta,
    output logic [SIDX_W-1:0] ld_idx,
    output logic [SIDX_W-1:0] cur_idx,
    output logic              running
);
    thread_state_e st_q, st_d;
    logic [DW-1:0] rem_q;
    logic          reached;
    logic          advance;

    assign reached = ({1'b0, now} >= start_time);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TH_IDLE: if (go) st_d = TH_WAIT;
            TH_WAIT: begin
                if (!go)          st_d = TH_IDLE;
                else if (reached) st_d = TH_RUN;
            end
            TH_RUN:  if (!go) st_d = TH_IDLE;
            default: st_d = TH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TH_IDLE;
        else        st_q <= st_d;
    end

    // Slot to load next: the start address on entry or wrap, else the successor.
    always_comb begin
        if (st_q == TH_WAIT || cur_idx == end_idx) ld_idx = start_addr;
        else                                       ld_idx = cur_idx + SIDX_W'(1);
    end

    assign advance = (st_q == TH_RUN) && go && tick && (rem_q <= DW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx <= '0;
            rem_q   <= '0;
        end else if ((st_q == TH_WAIT && st_d == TH_RUN) || advance) begin
            cur_idx <= ld_idx;
            rem_q   <= ld_delta;
        end else if (st_q == TH_RUN && go && tick) begin
            rem_q   <= rem_q - DW'(1);
        end
    end

    assign running = (st_q == TH_RUN);
endmodule

// File: rtl/gcs_merge.sv
module gcs_merge #(
    parameter int N_THREADS = 8,
    parameter int N_PORTS   = 5,
    parameter int N_TC      = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [N_THREADS-1:0]                run_vec,
    input  logic [N_THREADS-1:0]                resv_vec,
    input  logic [N_THREADS-1:0][N_PORTS-1:0]   dest_vec,
    input  logic [N_THREADS-1:0][N_TC-1:0]      mask_vec,
    output logic [N_PORTS*N_TC-1:0]             gate_closed,
    output logic                                conflict
);
    logic [N_PORTS*N_TC-1:0] gate_d;
    logic                    conf_d;

    always_comb begin
        int hits;
        gate_d = '0;
        conf_d = 1'b0;
        for (int p = 0; p < N_PORTS; p++) begin
            hits = 0;
            for (int t = 0; t < N_THREADS; t++) begin
                if (run_vec[t] && dest_vec[t][p]) begin
                    hits = hits + 1;
                    if (resv_vec[t])
                        gate_d[p*N_TC +: N_TC] = gate_d[p*N_TC +: N_TC] | mask_vec[t];
                end
            end
            if (hits > 1) conf_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_closed <= '0;
            conflict    <= 1'b0;
        end else begin
            gate_closed <= gate_d;
            conflict    <= conf_d;
        end
    end
endmodule

// File: rtl/gcs_sched.sv
module gcs_sched
    import gcs_pkg::*;
#(
    parameter  int N_THREADS = 8,
    parameter  int N_SLOTS   = 16,
    parameter  int N_PORTS   = 5,
    parameter  int N_TC      = 8,
    parameter  int TIME_W    = 32,
    parameter  int TICK_DIV  = 40,
    parameter  int CFG_W     = 40,
    localparam int SIDX_W    = $clog2(N_SLOTS),
    localparam int TIDX_W    = $clog2(N_THREADS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sched_en,
    input  logic [TIME_W-1:0]       sched_base,
    input  logic [TIDX_W-1:0]       thread_last,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [SIDX_W-1:0]       cfg_addr,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [N_PORTS*N_TC-1:0] gate_closed,
    output logic                    conflict,
    output logic                    cfg_err
);
    localparam int DW       = DELTA_FIELD_W;
    localparam int MASK_LO  = DW;
    localparam int RESV_BIT = DW + N_TC;
    localparam int DEST_LO  = RESV_BIT + 1;
    localparam int SLOT_W   = DEST_LO + N_PORTS;

    sched_state_e st_q, st_d;

    logic [N_SLOTS-1:0][SLOT_W-1:0]  slot_q;
    logic [N_THREADS-1:0][DW-1:0]    ep_delta_q;
    logic [N_THREADS-1:0][SIDX_W-1:0] ep_addr_q;
    logic [N_THREADS-1:0][SIDX_W-1:0] end_q;

    logic              run_on, cfg_open;
    logic              wr_slot, wr_entry, wr_end, bad_delta;
    logic [DW-1:0]     wr_delta;
    logic              tick;
    logic [TIME_W-1:0] now;

    logic [N_THREADS-1:0]               thr_run;
    logic [N_THREADS-1:0]               thr_resv;
    logic [N_THREADS-1:0][SIDX_W-1:0]   thr_cur;
    logic [N_THREADS-1:0][N_PORTS-1:0]  thr_dest;
    logic [N_THREADS-1:0][N_TC-1:0]     thr_mask;

    // Scheduler controller: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SC_OFF: begin
                if (sched_en) st_d = (sched_base == '0) ? SC_FAULT : SC_RUN;
            end
            SC_RUN:   if (!sched_en) st_d = SC_OFF;
            SC_FAULT: if (!sched_en) st_d = SC_OFF;
            default:  st_d = SC_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SC_OFF;
        else        st_q <= st_d;
    end

    // Controller outputs
    always_comb begin
        run_on   = (st_q == SC_RUN);
        cfg_open = !sched_en && (st_q == SC_OFF);
    end

    assign wr_delta  = cfg_wdata[DW-1:0];
    assign bad_delta = (wr_delta == '0) || wr_delta[DELTA_OVF_BIT];
    assign wr_slot   = cfg_we && cfg_open && (cfg_sel == CFG_SLOT)
                       && (int'(cfg_addr) < N_SLOTS);
    assign wr_entry  = cfg_we && cfg_open && (cfg_sel == CFG_ENTRY)
                       && (int'(cfg_addr) < N_THREADS);
    assign wr_end    = cfg_we && cfg_open && (cfg_sel == CFG_END)
                       && (int'(cfg_addr) < N_THREADS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q     <= '0;
            ep_delta_q <= '0;
            ep_addr_q  <= '0;
            end_q      <= '0;
        end else begin
            if (wr_slot && !bad_delta)
                slot_q[cfg_addr] <= cfg_wdata[SLOT_W-1:0];
            if (wr_entry) begin
                ep_delta_q[cfg_addr[TIDX_W-1:0]] <= cfg_wdata[DW-1:0];
                ep_addr_q[cfg_addr[TIDX_W-1:0]]  <= cfg_wdata[DW +: SIDX_W];
            end
            if (wr_end)
                end_q[cfg_addr[TIDX_W-1:0]] <= cfg_wdata[SIDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if ((st_q == SC_OFF && st_d == SC_FAULT) || (wr_slot && bad_delta))
            cfg_err <= 1'b1;
    end

    gcs_timebase #(
        .TICK_DIV (TICK_DIV),
        .TIME_W   (TIME_W)
    ) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_on),
        .tick  (tick),
        .now   (now)
    );

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        logic              go;
        logic [SIDX_W-1:0] ld_idx;
        logic [TIME_W:0]   start_time;

        assign go         = run_on && (TIDX_W'(t) <= thread_last);
        assign start_time = {1'b0, sched_base} + (TIME_W+1)'(ep_delta_q[t]);

        gcs_thread #(
            .SIDX_W (SIDX_W),
            .DW     (DW),
            .TIME_W (TIME_W)
        ) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .go         (go),
            .tick       (tick),
            .now        (now),
            .start_time (start_time),
            .start_addr (ep_addr_q[t]),
            .end_idx    (end_q[t]),
            .ld_delta   (slot_q[ld_idx][DW-1:0]),
            .ld_idx     (ld_idx),
            .cur_idx    (thr_cur[t]),
            .running    (thr_run[t])
        );

        assign thr_dest[t] = slot_q[thr_cur[t]][DEST_LO +: N_PORTS];
        assign thr_mask[t] = slot_q[thr_cur[t]][MASK_LO +: N_TC];
        assign thr_resv[t] = slot_q[thr_cur[t]][RESV_BIT];
    end

    gcs_merge #(
        .N_THREADS (N_THREADS),
        .N_PORTS   (N_PORTS),
        .N_TC      (N_TC)
    ) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_vec     (thr_run),
        .resv_vec    (thr_resv),
        .dest_vec    (thr_dest),
        .mask_vec    (thr_mask),
        .gate_closed (gate_closed),
        .conflict    (conflict)
    );
endmodule

// File: rtl/gcs_sched_chk.sv
module gcs_sched_chk
    import gcs_pkg::*;
#(
    parameter  int N_THREADS = 8,
    parameter  int N_SLOTS   = 16,
    parameter  int N_PORTS   = 5,
    parameter  int N_TC      = 8,
    parameter  int TIME_W    = 32,
    parameter  int SLOT_W    = 34,
    localparam int TIDX_W    = $clog2(N_THREADS)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sched_en,
    input logic [TIME_W-1:0]              sched_base,
    input logic [TIDX_W-1:0]              thread_last,
    input logic [N_PORTS*N_TC-1:0]        gate_closed,
    input logic                           conflict,
    input logic                           cfg_err,
    input sched_state_e                   st_q,
    input logic [N_THREADS-1:0]           thr_run,
    input logic [N_SLOTS-1:0][SLOT_W-1:0] slot_q
);
    logic [1:0]           off_cnt;
    logic [N_THREADS-1:0] above_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             off_cnt <= '0;
        else if (sched_en)      off_cnt <= '0;
        else if (off_cnt != 2'd3) off_cnt <= off_cnt + 2'd1;
    end

    always_comb begin
        for (int t = 0; t < N_THREADS; t++)
            above_m[t] = (TIDX_W'(t) > thread_last);
    end

    AST_OFF_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (off_cnt == 2'd3) |-> (gate_closed == '0 && !conflict)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R7

    AST_BASE_ZERO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SC_OFF && sched_en && sched_base == '0) |=> (cfg_err && thr_run == '0)); // R8

    AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sched_en |=> $stable(slot_q)); // R9

    AST_CONFLICT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> $past($countones(thr_run) > 1)); // R10

    AST_IDLE_ABOVE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_run & above_m) == '0); // R6
endmodule

bind gcs_sched gcs_sched_chk #(
    .N_THREADS (N_THREADS),
    .N_SLOTS   (N_SLOTS),
    .N_PORTS   (N_PORTS),
    .N_TC      (N_TC),
    .TIME_W    (TIME_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sched_en    (sched_en),
    .sched_base  (sched_base),
    .thread_last (thread_last),
    .gate_closed (gate_closed),
    .conflict    (conflict),
    .cfg_err     (cfg_err),
    .st_q        (st_q),
    .thr_run     (thr_run),
    .slot_q      (slot_q)
);

// File: tb/gcs_sched_tb_top.sv
`timescale 1ns/1ps
module gcs_sched_tb_top;
    localparam int NT   = 8;
    localparam int NS   = 16;
    localparam int NP   = 5;
    localparam int NTC  = 8;
    localparam int TW   = 32;
    localparam int DIV  = 40;
    localparam int CW   = 40;

    typedef struct {
        logic [NP*NTC-1:0] gate;
        logic              conf;
        string             tag;
        int                unit;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sched_en = 1'b0;
    logic [TW-1:0]     sched_base = '0;
    logic [2:0]        thread_last = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [3:0]        cfg_addr = '0;
    logic [CW-1:0]     cfg_wdata = '0;
    logic [NP*NTC-1:0] gate_closed;
    logic              conflict;
    logic              cfg_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    exp_item_t sb_q[$];
    event      smp_ev;

    int m_delta[NS], m_mask[NS], m_resv[NS], m_dest[NS];
    int m_epd[NT], m_addr[NT], m_end[NT];
    bit exp_err;

    always #2.5 clk = ~clk;

    gcs_sched #(
        .N_THREADS (NT), .N_SLOTS (NS), .N_PORTS (NP), .N_TC (NTC),
        .TIME_W (TW), .TICK_DIV (DIV), .CFG_W (CW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sched_en (sched_en),
        .sched_base (sched_base), .thread_last (thread_last),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .gate_closed (gate_closed),
        .conflict (conflict), .cfg_err (cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model of the requirements
    function automatic void model(input int n, output logic [NP*NTC-1:0] g, output logic c);
        int hits[NP];
        g = '0;
        c = 1'b0;
        for (int p = 0; p < NP; p++) hits[p] = 0;
        for (int i = 0; i < NT; i++) begin
            int st, len, off, k;
            if (sched_base == 0 || i > int'(thread_last)) continue;
            st = int'(sched_base) + m_epd[i];
            if (n < st) continue;
            len = 0;
            for (int j = m_addr[i]; j <= m_end[i]; j++) len += m_delta[j];
            off = (n - st) % len;
            k = m_addr[i];
            while (off >= m_delta[k]) begin
                off -= m_delta[k];
                k++;
            end
            for (int p = 0; p < NP; p++) begin
                if (m_dest[k][p]) begin
                    hits[p]++;
                    if (m_resv[k] != 0) g[p*NTC +: NTC] = g[p*NTC +: NTC] | NTC'(m_mask[k]);
                end
            end
        end
        for (int p = 0; p < NP; p++) if (hits[p] > 1) c = 1'b1;
    endfunction

    function automatic logic [CW-1:0] slot_w(input int d, input int m, input int r, input int dst);
        logic [CW-1:0] w;
        w = '0;
        w[19:0]  = 20'(d);
        w[27:20] = 8'(m);
        w[28]    = r[0];
        w[33:29] = 5'(dst);
        return w;
    endfunction

    function automatic logic [CW-1:0] ep_w(input int d, input int a);
        logic [CW-1:0] w;
        w = '0;
        w[19:0]  = 20'(d);
        w[23:20] = 4'(a);
        return w;
    endfunction

    task automatic wr(input logic [1:0] sel, input int addr, input logic [CW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 4'(addr); cfg_wdata = data;
        if (!sched_en) begin
            if (sel == 2'd0) begin
                int d;
                d = int'(data[19:0]);
                if (d == 0 || d >= (1 << 19)) exp_err = 1'b1;
                else begin
                    m_delta[addr] = d; m_mask[addr] = int'(data[27:20]);
                    m_resv[addr] = int'(data[28]); m_dest[addr] = int'(data[33:29]);
                end
            end else if (sel == 2'd1) begin
                m_epd[addr] = int'(data[19:0]); m_addr[addr] = int'(data[23:20]);
            end else if (sel == 2'd2) begin
                m_end[addr] = int'(data[3:0]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sched_en = 1'b0;
        for (int i = 0; i < NS; i++) begin
            m_delta[i] = 0; m_mask[i] = 0; m_resv[i] = 0; m_dest[i] = 0;
        end
        for (int i = 0; i < NT; i++) begin
            m_epd[i] = 0; m_addr[i] = 0; m_end[i] = 0;
        end
        exp_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Enables the scheduler and samples the middle of units 0..units-1
    task automatic run_window(input int units, input string tag, input int wr_at);
        @(negedge clk);
        sched_en = 1'b1;
        @(posedge clk);
        repeat (DIV/2) @(posedge clk);
        @(negedge clk);
        for (int n = 0; n < units; n++) begin
            exp_item_t it;
            model(n, it.gate, it.conf);
            it.tag = tag;
            it.unit = n;
            sb_q.push_back(it);
            -> smp_ev;
            if (n == wr_at) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_addr = 4'd0;
                cfg_wdata = slot_w(7, 8'h55, 1, 5'b11111);
            end
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
            repeat (DIV-1) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic stop_run(input string tag);
        @(negedge clk);
        sched_en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(gate_closed == '0 && !conflict, tag, 64'({conflict, gate_closed}), 64'd0);
    endtask

    task automatic prog_a();
        wr(2'd0, 0, slot_w(2, 8'h0F, 1, 5'b00001));
        wr(2'd0, 1, slot_w(3, 8'hF0, 1, 5'b00001));
        wr(2'd0, 2, slot_w(1, 8'h81, 1, 5'b00001));
        wr(2'd0, 3, slot_w(4, 8'h33, 1, 5'b00010));
        wr(2'd0, 4, slot_w(2, 8'hFF, 0, 5'b00010));
        wr(2'd1, 0, ep_w(1, 0));
        wr(2'd1, 1, ep_w(3, 3));
        wr(2'd1, 2, ep_w(0, 3));
        wr(2'd2, 0, 40'd2);
        for (int i = 1; i < NT; i++) wr(2'd2, i, 40'd4);
        thread_last = 3'd1;
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(smp_ev);
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard", 64'd0, 64'd1);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (gate_closed !== it.gate || conflict !== it.conf) begin
                    n_errors++;
                    $display("FAIL %s unit %0d: actual gates %h conflict %b expected gates %h conflict %b",
                             it.tag, it.unit, gate_closed, conflict, it.gate, it.conf);
                end
            end
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(gate_closed == '0 && !conflict && !cfg_err, "R1",
            64'({cfg_err, conflict, gate_closed}), 64'd0);

        // R2 R3 R4 R5 R6, with a write during the run for R9
        prog_a();
        sched_base = 32'd2;
        run_window(26, "R2 R3 R4 R5 R6 R9", 10);
        stop_run("R11");
        chk(cfg_err == 1'b0, "R7", 64'(cfg_err), 64'd0);

        // R7: illegal durations are dropped and flagged
        wr(2'd0, 0, slot_w(0, 8'h3C, 1, 5'b00100));
        wr(2'd0, 1, slot_w(1 << 19, 8'h3C, 1, 5'b00100));
        chk(cfg_err == 1'b1, "R7", 64'(cfg_err), 64'd1);
        run_window(14, "R7 R11", -1);
        stop_run("R11");

        // R8: base time of zero
        do_reset();
        chk(cfg_err == 1'b0, "R1", 64'(cfg_err), 64'd0);
        prog_a();
        sched_base = 32'd0;
        run_window(8, "R8", -1);
        chk(cfg_err == 1'b1, "R8", 64'(cfg_err), 64'd1);
        stop_run("R11");

        // R10: two threads on one port
        do_reset();
        wr(2'd0, 0, slot_w(3, 8'h01, 1, 5'b00101));
        wr(2'd0, 1, slot_w(2, 8'h02, 1, 5'b00100));
        wr(2'd0, 2, slot_w(1, 8'h04, 1, 5'b01000));
        wr(2'd1, 0, ep_w(0, 0));
        wr(2'd1, 1, ep_w(2, 1));
        wr(2'd2, 0, 40'd0);
        for (int i = 1; i < NT; i++) wr(2'd2, i, 40'd2);
        thread_last = 3'd1;
        sched_base = 32'd1;
        run_window(16, "R10", -1);
        stop_run("R11");
        chk(cfg_err == 1'b0, "R7", 64'(cfg_err), 64'd0);

        repeat (5) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule